// File: doc/BRIEF.md
# Pattern-Based Clock Pulse Squasher

This block sits after a clock divider and removes chosen pulses from the clock it receives. A control word holds three things: an enable bit, a window-length field and a 16-bit pattern. While squashing is on, the block walks through the active part of the pattern, one bit per input cycle. Cycles whose bit is 1 pass and cycles whose bit is 0 are dropped. The block gives its result in two forms. One is a clock-enable for logic that runs on the source clock. The other is a gated clock from a latch-based gate, which cannot glitch.

The window length is stored as length minus one. The pattern is aligned to the most significant bit, so only the upper `length` bits take part. The output rate is therefore (ones in the window / window length) × (source rate). The block reports both the window length and the number of ones in it. Software can use these to work out the effective frequency. The source clock itself is a fixed multiple of the reference: the PLL ratio is held at 34 and is then divided. Software computes the squashed frequency from that source rate.

A new word enters through a load strobe and waits in a pending stage. It becomes active only at the end of a window, so a pattern is never cut short. With squashing off, every cycle counts as a window end, and every pulse passes.

Top module: `clk_squasher`

## Requirements
- R1: While the active word has its enable bit at 0, `pass_en` is 1 in every cycle, `win_len` reads 16 and `win_pop` reads 16.
- R2: While enabled, `win_len` equals the size field plus 1 (size 0 gives 1, size 15 gives 16).
- R3: Only pattern bits 15 down to 15-size take part. Changing pattern bits below that position changes neither `pass_en` nor `win_pop`.
- R4: While enabled, the cycle at window position p (p = 0 is the first cycle after the word takes effect) has `pass_en` equal to pattern bit 15-p. The position advances by one each cycle and returns to 0 after position `size`.
- R5: A word is captured on a cycle with `cfg_load` high. It becomes active at the first window end after it was captured, and the cycle after that window end is position 0 of the new word. A later load before that point replaces the pending word.
- R6: While enabled, `win_pop` equals the number of 1 bits among pattern bits 15 down to 15-size.
- R7: `gclk` is low whenever `clk` is low. During the high phase after a rising edge, `gclk` follows the `pass_en` value of the cycle that ended at that edge.
- R8: An enabled word with an all-zero active pattern gives no `gclk` pulses. Size 15 with pattern 0xFFFF passes every cycle, like the disabled case.
- R9: After reset the active word is disabled (size 15, pattern 0xFFFF) and no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the control word |
| cfg_en | input | 1 | Squash enable of the word being loaded |
| cfg_size | input | 4 | Window length minus one |
| cfg_wave | input | 16 | Pulse pattern, aligned to the MSB |
| pass_en | output | 1 | Clock enable: the current cycle passes |
| gclk | output | 1 | Glitch-free gated clock |
| win_len | output | 5 | Active window length (1..16) |
| win_pop | output | 5 | Ones in the active window (0..16) |

## Verification
The hardest case to bring about is a load that lands close to a window end. This includes a load in the very cycle of the window end, where the previously pending word moves to active while the new word takes the pending slot. The bench issues loads at fixed offsets within short windows and also at random cycles with random sizes, so these collisions happen often. A behavioural model applies R5 on every cycle and flags any early or late switch.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int WAVE_W = 16;
  localparam int SIZE_W = $clog2(WAVE_W);
  localparam int POP_W  = $clog2(WAVE_W + 1);

  typedef struct packed {
    logic              en;
    logic [SIZE_W-1:0] size;
    logic [WAVE_W-1:0] wave;
  } sq_cfg_t;

  localparam sq_cfg_t CFG_RESET = '{en: 1'b0, size: SIZE_W'(WAVE_W - 1), wave: '1};

  // keep only the upper size+1 bits of the pattern
  function automatic logic [WAVE_W-1:0] active_mask(input logic [SIZE_W-1:0] size);
    logic [WAVE_W-1:0] m;
    for (int i = 0; i < WAVE_W; i++)
      m[i] = (i >= (WAVE_W - 1 - int'(size)));
    return m;
  endfunction

  function automatic logic [POP_W-1:0] ones_in(input logic [WAVE_W-1:0] v);
    logic [POP_W-1:0] c;
    c = '0;
    for (int i = 0; i < WAVE_W; i++)
      c = c + POP_W'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/sq_cfg_stage.sv
module sq_cfg_stage
  import sq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  sq_cfg_t load_cfg,
  input  logic    boundary,
  output sq_cfg_t act_cfg
);
  sq_cfg_t pend_cfg;
  logic    pend_valid;
  logic    take_pend;

  assign take_pend = boundary && pend_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cfg   <= CFG_RESET;
      pend_valid <= 1'b0;
      act_cfg    <= CFG_RESET;
    end else begin
      if (load) begin
        pend_cfg   <= load_cfg;
        pend_valid <= 1'b1;
      end else if (take_pend) begin
        pend_valid <= 1'b0;
      end
      if (take_pend) act_cfg <= pend_cfg;
    end
  end

  AST_CFG_HOLD_MIDWIN: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_cfg)); // R5
endmodule

// File: rtl/sq_walker.sv
module sq_walker
  import sq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sq_cfg_t           act_cfg,
  output logic [SIZE_W-1:0] pos,
  output logic              boundary,
  output logic              pass_en
);
  logic [SIZE_W-1:0] bit_idx;

  assign boundary = !act_cfg.en || (pos == act_cfg.size);
  assign bit_idx  = SIZE_W'(WAVE_W - 1) - pos;
  assign pass_en  = act_cfg.en ? act_cfg.wave[bit_idx] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (boundary) pos <= '0;
    else               pos <= pos + 1'b1;
  end

  AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    act_cfg.en |-> pos <= act_cfg.size); // R4
  AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> pos == '0); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> pos == $past(pos) + 1'b1); // R4
  AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !act_cfg.en |-> pass_en); // R1
endmodule

// File: rtl/sq_gate.sv
module sq_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // transparent only while clk is low, so gclk cannot glitch
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/clk_squasher.sv
module clk_squasher
  import sq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_en,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [WAVE_W-1:0] cfg_wave,
  output logic              pass_en,
  output logic              gclk,
  output logic [POP_W-1:0]  win_len,
  output logic [POP_W-1:0]  win_pop
);
  sq_cfg_t           load_cfg, act_cfg;
  logic              boundary;
  logic [SIZE_W-1:0] pos;

  assign load_cfg = '{en: cfg_en, size: cfg_size, wave: cfg_wave};

  sq_cfg_stage u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_cfg(load_cfg),
    .boundary(boundary), .act_cfg(act_cfg)
  );

  sq_walker u_walk (
    .clk(clk), .rst_n(rst_n), .act_cfg(act_cfg),
    .pos(pos), .boundary(boundary), .pass_en(pass_en)
  );

  sq_gate u_gate (.clk(clk), .en(pass_en), .gclk(gclk));

  assign win_len = act_cfg.en ? POP_W'(act_cfg.size) + 1'b1 : POP_W'(WAVE_W);
  assign win_pop = act_cfg.en ? ones_in(act_cfg.wave & active_mask(act_cfg.size))
                              : POP_W'(WAVE_W);

  AST_POP_LE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    win_pop <= win_len); // R6
  AST_PASS_NEEDS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pop == '0) |-> !pass_en); // R8
endmodule

// File: tb/tb_clk_squasher.sv
module tb_clk_squasher;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_en = 1'b0;
  logic [3:0] cfg_size = '0;
  logic [15:0] cfg_wave = '0;
  logic pass_en, gclk;
  logic [4:0] win_len, win_pop;

  int tests = 0, fails = 0, pulses = 0;
  string scen = "R9";

  // behavioural model state
  int m_en = 0, m_size = 15, m_wave = 'hFFFF, m_pos = 0;
  int p_en = 0, p_size = 15, p_wave = 'hFFFF, p_v = 0;

  clk_squasher dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) at %0t: actual %0d expected %0d", req, scen, $time, act, exp);
    end
  endtask

  function automatic int m_pass();
    if (m_en == 0) return 1;
    return (m_wave >> (15 - m_pos)) & 1;
  endfunction

  function automatic int m_pop();
    int c = 0;
    if (m_en == 0) return 16;
    for (int b = 0; b <= m_size; b++) c += (m_wave >> (15 - b)) & 1;
    return c;
  endfunction

  task automatic tick(input bit ld, input int en, input int sz, input int wv);
    int exp_p, wrap, n_pos;
    cfg_load = ld; cfg_en = en[0]; cfg_size = sz[3:0]; cfg_wave = wv[15:0];
    #1;
    exp_p = m_pass();
    chk(pass_en == exp_p[0], (m_en != 0) ? "R4" : "R1", pass_en, exp_p);
    chk(win_len == ((m_en != 0) ? m_size + 1 : 16), (m_en != 0) ? "R2" : "R1", win_len,
        (m_en != 0) ? m_size + 1 : 16);
    chk(win_pop == m_pop(), (m_en != 0) ? "R6" : "R1", win_pop, m_pop());
    chk(gclk == 1'b0, "R7", gclk, 0);
    wrap = (m_en == 0) || (m_pos == m_size);
    n_pos = wrap ? 0 : m_pos + 1;
    @(posedge clk); #1;
    chk(gclk == exp_p[0], "R7", gclk, exp_p);
    if (gclk) pulses++;
    if (wrap && p_v) begin m_en = p_en; m_size = p_size; m_wave = p_wave; end
    if (ld) begin p_en = en; p_size = sz & 15; p_wave = wv & 'hFFFF; p_v = 1; end
    else if (wrap) p_v = 0;
    m_pos = n_pos;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt_a, cnt_b;
    @(negedge clk); @(negedge clk);
    #1;
    chk(pass_en == 1'b1, "R9", pass_en, 1);
    chk(win_len == 5'd16, "R9", win_len, 16);
    chk(win_pop == 5'd16, "R9", win_pop, 16);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    scen = "R1 disabled"; idle(5);

    scen = "R4 basic";
    tick(1'b1, 1, 7, 'hB400); idle(20);

    scen = "R3 low bits ignored";
    pulses = 0; tick(1'b1, 1, 7, 'hB400); idle(31); cnt_a = pulses;
    pulses = 0; tick(1'b1, 1, 7, 'hB4FF); idle(31); cnt_b = pulses;
    chk(cnt_a == cnt_b, "R3", cnt_b, cnt_a);

    scen = "R5 midwindow load";
    tick(1'b1, 1, 3, 'h5000); idle(5);
    tick(1'b1, 1, 5, 'hA800); idle(1);
    tick(1'b1, 1, 2, 'hC000); idle(12);
    tick(1'b1, 1, 1, 'h4000); tick(1'b1, 1, 2, 'h6000); idle(10);

    scen = "R8 all zero";
    tick(1'b1, 1, 15, 'h0000); idle(20);
    pulses = 0; idle(16);
    chk(pulses == 0, "R8", pulses, 0);

    scen = "R8 full ones";
    tick(1'b1, 1, 15, 'hFFFF); idle(20);
    pulses = 0; idle(16);
    chk(pulses == 16, "R8", pulses, 16);

    scen = "R2 size zero";
    tick(1'b1, 1, 0, 'h8000); idle(6);
    tick(1'b1, 1, 0, 'h7FFF); idle(6);

    scen = "R5 random loads";
    for (int k = 0; k < 60; k++) begin
      tick(1'b1, ($urandom % 5) != 0, $urandom % 16, $urandom % 65536);
      idle($urandom % 12);
    end

    scen = "R1 disable again";
    tick(1'b1, 0, 3, 'h0000); idle(20);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule